// File: doc/BRIEF.md
# Serial Shift-Register Access Controller

This block lets on-chip logic load and inspect a small external static shift register that has no parallel port, no clear and no preset. The register is reached through three pins: a clock the controller produces, a data line into the register and a data line out of the register's last stage. Each shift of the external chain moves one bit in and one bit out, so every access reads and writes at the same time.

The controller does not divide down a clock to make the serial clock. A state machine runs on the system clock and spends a programmable number of system cycles with the serial clock high and the data set up, then a number of cycles with the serial clock low while the data is held. The hold count is derived from the system clock period and the required hold time, so the falling sampling edge always sits inside a stable data window. A write access shifts a new pattern in and returns the old one. A read-back access drives every bit seen on the register's output straight back into its input, so the register ends exactly as it started and its contents still come back on the read-data output.

The user raises `start_i` for one cycle with `mode_i` and `wdata_i` valid, waits for `done_o`, and takes `rdata_o` in that cycle.

Top module: `sreg_access_ctrl`

## Requirements
- R1: After synchronous reset the controller is idle: `busy_o`=0, `done_o`=0, `sr_clk_o`=1, `sr_din_o`=0, `rdata_o`=0; whenever idle, `sr_clk_o` is 1 and `sr_din_o` is 0.
- R2: Every accepted access produces exactly REG_BITS falling edges on `sr_clk_o` and keeps `busy_o` high for exactly REG_BITS*(SETUP_CYC+HOLD_CYC) cycles, starting in the cycle after `start_i` is seen.
- R3: With `mode_i`=0 (write), the external register holds `wdata_i` after the access; bits are driven most significant first.
- R4: `rdata_o` returns the external register's contents from before the access, the first bit seen on `sr_dout_i` placed at bit REG_BITS-1.
- R5: With `mode_i`=1 (read-back), each bit seen on `sr_dout_i` is driven onto `sr_din_o`, so the external register is unchanged after the access.
- R6: Each low phase of `sr_clk_o` lasts exactly HOLD_CYC cycles with `sr_din_o` stable, where HOLD_CYC is the larger of HOLD_MIN_CYC and ceil(HOLD_PS/SYS_CLK_PS).
- R7: Each high phase of `sr_clk_o` during an access lasts SETUP_CYC cycles before the falling edge, with `sr_din_o` stable throughout.
- R8: `done_o` is a single-cycle pulse in the first cycle after `busy_o` drops, and `rdata_o` is valid in that cycle.
- R9: `start_i` while `busy_o`=1 is ignored: it neither lengthens the access nor queues another one.
- R10: `mode_i` and `wdata_i` are taken only in the cycle `start_i` is accepted; changing them during an access has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request an access (accepted only when idle) |
| mode_i | input | 1 | 0 = write new pattern, 1 = read-back (contents preserved) |
| wdata_i | input | REG_BITS | Pattern to shift in during a write |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle pulse when the access completes |
| rdata_o | output | REG_BITS | Contents captured from the external register |
| sr_clk_o | output | 1 | Serial clock to the external register (samples on fall) |
| sr_din_o | output | 1 | Serial data into the external register |
| sr_dout_i | input | 1 | Serial data from the external register's last stage |

## Verification
The checks assume that `sr_dout_i` only changes as a result of a falling edge on `sr_clk_o` and settles well before the next set-up phase ends, as a static register on a short trace does; the bench models the external register as an eight-stage chain clocked on that falling edge so its output moves only then. They also assume `start_i` is a level the controller samples on the clock, with no constraint on how long it stays high. The stimulus respects both: the modelled register shifts only on the serial clock, and start requests are driven between clock edges, including deliberate requests and data changes in the middle of an access.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

   typedef enum logic [1:0] {
      SR_IDLE  = 2'd0,
      SR_SETUP = 2'd1,
      SR_HOLD  = 2'd2
   } sr_state_e;

   function automatic int unsigned sr_ceil_div(input int unsigned num, input int unsigned den);
      return (num + den - 1) / den;
   endfunction

   function automatic int unsigned sr_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sreg_phase_timer.sv
module sreg_phase_timer #(
   parameter int unsigned MAX_CNT = 4,
   localparam int unsigned CNT_W = (MAX_CNT > 1) ? $clog2(MAX_CNT) : 1
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic             expire_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expire_o = (cnt_q == '0);

endmodule

// File: rtl/sreg_data_path.sv
module sreg_data_path #(
   parameter int unsigned REG_BITS = 8
) (
   input  logic                clk_i,
   input  logic                rst_i,
   input  logic                accept_i,
   input  logic                next_bit_i,
   input  logic                finish_i,
   input  logic                mode_i,
   input  logic [REG_BITS-1:0] wdata_i,
   input  logic                sr_dout_i,
   output logic                sr_din_o,
   output logic [REG_BITS-1:0] rdata_o
);

   logic [REG_BITS-1:0] wbuf_q;
   logic [REG_BITS-1:0] cap_q;
   logic                mode_q;
   logic                din_q;

   // Bits leave from the top: the write buffer always presents its next bit at the MSB.
   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         wbuf_q  <= '0;
         cap_q   <= '0;
         mode_q  <= 1'b0;
         din_q   <= 1'b0;
         rdata_o <= '0;
      end else if (accept_i) begin
         mode_q <= mode_i;
         wbuf_q <= {wdata_i[REG_BITS-2:0], 1'b0};
         din_q  <= mode_i ? sr_dout_i : wdata_i[REG_BITS-1];
         cap_q  <= {cap_q[REG_BITS-2:0], sr_dout_i};
      end else if (next_bit_i) begin
         wbuf_q <= {wbuf_q[REG_BITS-2:0], 1'b0};
         din_q  <= mode_q ? sr_dout_i : wbuf_q[REG_BITS-1];
         cap_q  <= {cap_q[REG_BITS-2:0], sr_dout_i};
      end else if (finish_i) begin
         din_q   <= 1'b0;
         rdata_o <= cap_q;
      end
   end

   assign sr_din_o = din_q;

endmodule

// File: rtl/sreg_access_ctrl.sv
module sreg_access_ctrl
   import sreg_pkg::*;
#(
   parameter int unsigned REG_BITS     = 8,
   parameter int unsigned SYS_CLK_PS   = 10000,
   parameter int unsigned HOLD_PS      = 5000,
   parameter int unsigned HOLD_MIN_CYC = 2,
   parameter int unsigned SETUP_CYC    = 3
) (
   input  logic                clk_i,
   input  logic                rst_i,
   input  logic                start_i,
   input  logic                mode_i,
   input  logic [REG_BITS-1:0] wdata_i,
   output logic                busy_o,
   output logic                done_o,
   output logic [REG_BITS-1:0] rdata_o,
   output logic                sr_clk_o,
   output logic                sr_din_o,
   input  logic                sr_dout_i
);

   localparam int unsigned HOLD_TIME_CYC = sr_ceil_div(HOLD_PS, SYS_CLK_PS);
   localparam int unsigned HOLD_CYC      = sr_max(HOLD_MIN_CYC, HOLD_TIME_CYC);
   localparam int unsigned MAX_CNT       = sr_max(HOLD_CYC, SETUP_CYC);
   localparam int unsigned CNT_W         = (MAX_CNT > 1) ? $clog2(MAX_CNT) : 1;
   localparam int unsigned BIT_W         = $clog2(REG_BITS);
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(REG_BITS - 1);
   localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
   localparam logic [CNT_W-1:0] HOLD_LD  = CNT_W'(HOLD_CYC - 1);

   initial begin
      assert (REG_BITS >= 2) else $error("REG_BITS must be at least 2");
      assert (SETUP_CYC >= 1) else $error("SETUP_CYC must be at least 1");
      assert (HOLD_MIN_CYC >= 1) else $error("HOLD_MIN_CYC must be at least 1");
      assert (SYS_CLK_PS >= 1) else $error("SYS_CLK_PS must be nonzero");
   end

   sr_state_e        state_q;
   logic [BIT_W-1:0] bit_q;
   logic             sck_q;
   logic             done_q;
   logic             t_expire;
   logic             t_load;
   logic [CNT_W-1:0] t_val;
   logic             accept;
   logic             next_bit;
   logic             finish;

   assign accept   = start_i && (state_q == SR_IDLE);
   assign next_bit = (state_q == SR_HOLD) && t_expire && (bit_q != LAST_BIT);
   assign finish   = (state_q == SR_HOLD) && t_expire && (bit_q == LAST_BIT);

   always_comb begin
      t_load = 1'b0;
      t_val  = SETUP_LD;
      if (accept || next_bit) begin
         t_load = 1'b1;
         t_val  = SETUP_LD;
      end else if ((state_q == SR_SETUP) && t_expire) begin
         t_load = 1'b1;
         t_val  = HOLD_LD;
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         state_q <= SR_IDLE;
         bit_q   <= '0;
         sck_q   <= 1'b1;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            SR_IDLE: begin
               if (start_i) begin
                  state_q <= SR_SETUP;
                  bit_q   <= '0;
               end
            end
            SR_SETUP: begin
               if (t_expire) begin
                  state_q <= SR_HOLD;
                  sck_q   <= 1'b0;
               end
            end
            SR_HOLD: begin
               if (t_expire) begin
                  sck_q <= 1'b1;
                  if (bit_q == LAST_BIT) begin
                     state_q <= SR_IDLE;
                     done_q  <= 1'b1;
                  end else begin
                     state_q <= SR_SETUP;
                     bit_q   <= bit_q + 1'b1;
                  end
               end
            end
            default: state_q <= SR_IDLE;
         endcase
      end
   end

   sreg_phase_timer #(
      .MAX_CNT (MAX_CNT)
   ) u_timer (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .load_i     (t_load),
      .load_val_i (t_val),
      .expire_o   (t_expire)
   );

   sreg_data_path #(
      .REG_BITS (REG_BITS)
   ) u_data (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .accept_i   (accept),
      .next_bit_i (next_bit),
      .finish_i   (finish),
      .mode_i     (mode_i),
      .wdata_i    (wdata_i),
      .sr_dout_i  (sr_dout_i),
      .sr_din_o   (sr_din_o),
      .rdata_o    (rdata_o)
   );

   assign busy_o   = (state_q != SR_IDLE);
   assign done_o   = done_q;
   assign sr_clk_o = sck_q;

endmodule

// File: rtl/sreg_access_ctrl_chk.sv
module sreg_access_ctrl_chk #(
   parameter int unsigned REG_BITS  = 8,
   parameter int unsigned HOLD_CYC  = 2,
   parameter int unsigned SETUP_CYC = 3
) (
   input logic clk_i,
   input logic rst_i,
   input logic start_i,
   input logic busy_o,
   input logic done_o,
   input logic sr_clk_o,
   input logic sr_din_o
);

   logic        sck_prev_q;
   int unsigned falls_q;
   int unsigned low_run_q;
   int unsigned high_run_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         sck_prev_q <= 1'b1;
         falls_q    <= 0;
         low_run_q  <= 0;
         high_run_q <= 0;
      end else begin
         sck_prev_q <= sr_clk_o;
         if (start_i && !busy_o) begin
            falls_q <= 0;
         end else if (sck_prev_q && !sr_clk_o) begin
            falls_q <= falls_q + 1;
         end
         low_run_q  <= sr_clk_o ? 0 : low_run_q + 1;
         high_run_q <= (sr_clk_o && busy_o) ? high_run_q + 1 : 0;
      end
   end

   // R1: idle pins
   a_r1_idle_pins: assert property (@(posedge clk_i) disable iff (rst_i)
      !busy_o |-> (sr_clk_o && !sr_din_o));

   // R2: full shift on every access
   a_r2_full_shift: assert property (@(posedge clk_i) disable iff (rst_i)
      done_o |-> (falls_q == REG_BITS));

   // R6: data held while the clock is low, and low phase width
   a_r6_hold_stable: assert property (@(posedge clk_i) disable iff (rst_i)
      !sr_clk_o |=> (sr_clk_o || $stable(sr_din_o)));
   a_r6_hold_width: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(sr_clk_o) |-> (low_run_q == HOLD_CYC));

   // R7: data stable and setup width before each fall
   a_r7_setup_stable: assert property (@(posedge clk_i) disable iff (rst_i)
      (sr_clk_o && busy_o) |=> (!busy_o || !sr_clk_o || $stable(sr_din_o)));
   a_r7_setup_width: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(sr_clk_o) |-> (high_run_q == SETUP_CYC));

   // R8: done pulse shape
   a_r8_done_single: assert property (@(posedge clk_i) disable iff (rst_i)
      done_o |=> !done_o);
   a_r8_done_idle: assert property (@(posedge clk_i) disable iff (rst_i)
      done_o |-> !busy_o);
   a_r8_busy_end: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(busy_o) |-> done_o);

endmodule

bind sreg_access_ctrl sreg_access_ctrl_chk #(
   .REG_BITS  (REG_BITS),
   .HOLD_CYC  (HOLD_CYC),
   .SETUP_CYC (SETUP_CYC)
) u_chk (
   .clk_i    (clk_i),
   .rst_i    (rst_i),
   .start_i  (start_i),
   .busy_o   (busy_o),
   .done_o   (done_o),
   .sr_clk_o (sr_clk_o),
   .sr_din_o (sr_din_o)
);

// File: tb/sreg_access_ctrl_tb.sv
module sreg_access_ctrl_tb;

   localparam int unsigned W      = 8;
   localparam int unsigned SETUP  = 3;
   localparam int unsigned HOLD   = 2;   // max(2, ceil(5000/10000))
   localparam int unsigned ACCESS = W * (SETUP + HOLD);

   typedef struct packed {
      logic [W-1:0] rdata;
      logic [W-1:0] regval;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst;
   logic         start;
   logic         mode;
   logic [W-1:0] wdata;
   logic         busy, done, sck, din, dout;
   logic [W-1:0] rdata;
   logic [W-1:0] ext_reg = 8'h3C;

   int tests = 0;
   int fails = 0;
   exp_t sb_q[$];

   always #5 clk = ~clk;

   sreg_access_ctrl #(
      .REG_BITS     (W),
      .SYS_CLK_PS   (10000),
      .HOLD_PS      (5000),
      .HOLD_MIN_CYC (2),
      .SETUP_CYC    (SETUP)
   ) u_dut (
      .clk_i     (clk),
      .rst_i     (rst),
      .start_i   (start),
      .mode_i    (mode),
      .wdata_i   (wdata),
      .busy_o    (busy),
      .done_o    (done),
      .rdata_o   (rdata),
      .sr_clk_o  (sck),
      .sr_din_o  (din),
      .sr_dout_i (dout)
   );

   // External static shift register model: samples on the falling serial clock.
   always @(negedge sck) ext_reg <= {ext_reg[W-2:0], din};
   assign dout = ext_reg[W-1];

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Monitor: per-access timing counters and scoreboard compare on done.
   int   busy_cnt = 0, low_cnt = 0, high_cnt = 0, fall_cnt = 0, din_viol = 0;
   logic prev_sck = 1'b1, prev_din = 1'b0, prev_busy = 1'b0;

   always @(negedge clk) begin
      if (!rst) begin
         if (busy) begin
            busy_cnt++;
            if (sck) high_cnt++; else low_cnt++;
            if (prev_busy && prev_sck && !sck) fall_cnt++;
            if (prev_busy && (prev_sck == sck) && (prev_din != din)) din_viol++;
         end
         if (!busy && !done) begin
            chk(sck && !din, "R1 idle pins", {30'd0, sck, din}, 32'h2);
         end
         if (done) begin
            exp_t e;
            chk(sb_q.size() != 0, "R8 done without request", 0, 1);
            if (sb_q.size() != 0) begin
               e = sb_q.pop_front();
               chk(rdata == e.rdata, "R4 read data", rdata, e.rdata);
               chk(ext_reg == e.regval, "R3/R5 final register", ext_reg, e.regval);
            end
            chk(busy_cnt == ACCESS, "R2 busy length", busy_cnt, ACCESS);
            chk(fall_cnt == W, "R2 falling edges", fall_cnt, W);
            chk(low_cnt == W * HOLD, "R6 low cycles", low_cnt, W * HOLD);
            chk(high_cnt == W * SETUP, "R7 high cycles", high_cnt, W * SETUP);
            chk(din_viol == 0, "R6/R7 data stability", din_viol, 0);
            busy_cnt = 0; low_cnt = 0; high_cnt = 0; fall_cnt = 0; din_viol = 0;
         end
         prev_sck  = sck;
         prev_din  = din;
         prev_busy = busy;
      end
   end

   // Driver: pushes the expected result, then issues the access.
   task automatic do_access(input logic m, input logic [W-1:0] wd, input bit disturb);
      exp_t e;
      @(negedge clk);
      while (busy) @(negedge clk);
      e.rdata  = ext_reg;
      e.regval = m ? ext_reg : wd;
      sb_q.push_back(e);
      mode = m; wdata = wd; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (disturb) begin
         // R9 / R10: request and new operands in mid-access
         repeat (7) @(negedge clk);
         mode = ~m; wdata = ~wd; start = 1'b1;
         repeat (3) @(negedge clk);
         start = 1'b0;
      end
      while (!done) @(negedge clk);
      @(negedge clk);
      chk(!busy, "R9 no queued access", busy, 0);
      mode = 1'b0; wdata = '0;
   endtask

   initial begin
      int wd = 0;
      forever begin
         @(negedge clk);
         wd++;
         if (wd > 20000) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=%0d expected=<20000", wd);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
         end
      end
   end

   initial begin
      rst = 1'b1; start = 1'b0; mode = 1'b0; wdata = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1: reset state
      chk(!busy && !done, "R1 reset handshake", {30'd0, busy, done}, 0);
      chk(sck && !din, "R1 reset pins", {30'd0, sck, din}, 32'h2);
      chk(rdata == '0, "R1 reset rdata", rdata, 0);

      do_access(1'b0, 8'hC3, 1'b0);  // R3 write, R4 returns 3C
      do_access(1'b1, 8'h00, 1'b0);  // R5 read-back of C3
      do_access(1'b0, 8'h00, 1'b0);  // R3 all zeros
      do_access(1'b0, 8'hFF, 1'b1);  // R9/R10 disturbed write
      do_access(1'b1, 8'h12, 1'b1);  // R5/R10 disturbed read-back
      do_access(1'b0, 8'h5A, 1'b0);
      do_access(1'b1, 8'h00, 1'b0);
      do_access(1'b1, 8'hA5, 1'b0);
      do_access(1'b0, 8'h81, 1'b0);

      chk(sb_q.size() == 0, "R8 all results seen", sb_q.size(), 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule